// File: doc/BRIEF.md
# Quadword Payload RAM with Access Trace

A small read/write memory that a DMA engine reads its payload from. Both data paths carry one 128-bit quadword. Addresses arrive as byte addresses. The four least significant bits are dropped, so every access lands on a 16-byte-aligned quadword. Addresses beyond the array size fold back onto the array.

Reads have a fixed latency of one clock. A separate write port has one enable per byte lane, and a testbench uses it to preload payloads before a transfer starts.

Every access leaves a trace record on a dedicated output group. A record holds the aligned address, the low 32 bits of the data involved, a master identifier and a region identifier. Both identifiers are fixed by parameters and default to 1. A read and a write in the same cycle yield one record, and that record describes the read.

Top module: `qword_ram`

## Requirements
- R1: A quadword written with all 16 byte enables set is returned unchanged, all 128 bits, by a later read of the same address.
- R2: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high and low otherwise. `rd_data` carries the addressed quadword in that cycle.
- R3: Bit i of `wr_be` enables byte lane i, which is `wr_data[8i+7:8i]`. A lane whose enable is clear keeps its stored value.
- R4: Address bits [3:0] are ignored by both ports. Any byte address inside a quadword reaches the same storage. Trace addresses always report those four bits as zero.
- R5: The storage index is the byte address divided by 16, modulo `SIZE_BYTES`/16. With the default 4096 bytes, byte addresses 0x030, 0x1030 and 0x2030 all reach the same quadword.
- R6: A read and a write to the same address in one cycle return the old contents. The new contents appear on the next read.
- R7: Every read produces a trace record in the same cycle as its `rd_valid`. The record has `trc_valid`=1 and `trc_write`=0. It carries the aligned read address, and its `trc_summary` equals `rd_data[31:0]`.
- R8: Every trace record carries `trc_master` = `MASTER_ID` and `trc_region` = `REGION_ID`, which are both 1 by default.
- R9: A write in a cycle without a read produces a trace record in the following cycle, with `trc_write`=1, the aligned write address and `trc_summary` = `wr_data[31:0]`. A cycle with neither access gives `trc_valid`=0 in the following cycle. A write that coincides with a read produces no record of its own.
- R10: While and after reset, before any access, `rd_valid` and `trc_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_addr | input | 32 | Read byte address |
| rd_data | output | 128 | Read quadword |
| rd_valid | output | 1 | High the cycle after a read request |
| wr_en | input | 1 | Write request |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 128 | Write quadword |
| wr_be | input | 16 | Byte-lane write enables |
| trc_valid | output | 1 | Trace record present |
| trc_write | output | 1 | Record kind: 0 read, 1 write |
| trc_addr | output | 32 | Aligned address of the access |
| trc_summary | output | 32 | Low 32 data bits of the access |
| trc_master | output | 8 | Requesting master identifier |
| trc_region | output | 8 | Memory region identifier |

## Verification
The bench builds the block with its defaults: 4096 bytes (256 quadwords), a 128-bit data path, a 32-bit summary, tracing enabled, and both identifiers equal to 1. The small array puts aliasing within reach of ordinary addresses: 0x1030 and 0x2030 fold onto 0x030. The full-width path allows a partial byte-enable merge to be checked across all 16 lanes. With tracing enabled, the same-cycle read and write case exercises both read-first data and the read-over-write priority of the trace record.

// File: rtl/qram_pkg.sv
package qram_pkg;
   // bytes per quadword and the number of ignored address bits
   localparam int QW_BYTES = 16;
   localparam int QW_LSB   = 4;

   typedef enum logic {
      TRC_READ  = 1'b0,
      TRC_WRITE = 1'b1
   } trc_kind_e;
endpackage

// File: rtl/qram_addr_map.sv
module qram_addr_map #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] aligned
);
   import qram_pkg::*;

   if (ADDR_W < QW_LSB + IDX_W) begin : g_bad_addr_w
      $error("qram_addr_map: ADDR_W too small for the array index");
   end

   logic unused_low_bits;
   assign unused_low_bits = ^addr[QW_LSB-1:0];

   // index wraps naturally: upper address bits are dropped
   assign idx     = addr[QW_LSB +: IDX_W];
   assign aligned = {addr[ADDR_W-1:QW_LSB], {QW_LSB{1'b0}}};
endmodule

// File: rtl/qram_array.sv
module qram_array #(
   parameter int DATA_W = 128,
   parameter int DEPTH  = 256,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W/8-1:0] wr_be,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   localparam int LANES = DATA_W / 8;

   if (DATA_W % 8 != 0) begin : g_bad_data_w
      $error("qram_array: DATA_W must be a whole number of bytes");
   end
   if (DEPTH != (1 << IDX_W)) begin : g_bad_depth
      $error("qram_array: DEPTH must equal 2**IDX_W");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] rd_data_q;
   logic              rd_valid_q;

   // byte-lane write, each lane gated by its enable
   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int l = 0; l < LANES; l++) begin
            if (wr_be[l]) begin
               mem_q[wr_idx][l*8 +: 8] <= wr_data[l*8 +: 8];
            end
         end
      end
   end

   // registered read; samples the array before this edge's write lands
   always_ff @(posedge clk) begin
      if (rd_en) begin
         rd_data_q <= mem_q[rd_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
      end else begin
         rd_valid_q <= rd_en;
      end
   end

   assign rd_data  = rd_data_q;
   assign rd_valid = rd_valid_q;

   // R2
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   // R2
   rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
endmodule

// File: rtl/qram_tracer.sv
module qram_tracer #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 128,
   parameter int SUM_W     = 32,
   parameter int ID_W      = 8,
   parameter int MASTER_ID = 1,
   parameter int REGION_ID = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_aligned,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_aligned,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              rd_valid,
   output logic              trc_valid,
   output logic              trc_write,
   output logic [ADDR_W-1:0] trc_addr,
   output logic [SUM_W-1:0]  trc_summary,
   output logic [ID_W-1:0]   trc_master,
   output logic [ID_W-1:0]   trc_region
);
   import qram_pkg::*;

   if (SUM_W > DATA_W || SUM_W < 1) begin : g_bad_sum_w
      $error("qram_tracer: SUM_W must lie in 1..DATA_W");
   end
   if (MASTER_ID >= (1 << ID_W) || REGION_ID >= (1 << ID_W)) begin : g_bad_id
      $error("qram_tracer: identifier does not fit in ID_W");
   end

   logic              valid_q;
   trc_kind_e         kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SUM_W-1:0]  wsum_q;
   logic              unused_data;

   assign unused_data = ^{wr_data, rd_data};

   // a read takes the record slot; a lone write takes it otherwise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         kind_q  <= TRC_READ;
         addr_q  <= '0;
         wsum_q  <= '0;
      end else begin
         valid_q <= rd_en | wr_en;
         if (rd_en) begin
            kind_q <= TRC_READ;
            addr_q <= rd_aligned;
         end else if (wr_en) begin
            kind_q <= TRC_WRITE;
            addr_q <= wr_aligned;
            wsum_q <= wr_data[SUM_W-1:0];
         end
      end
   end

   assign trc_valid   = valid_q;
   assign trc_write   = (kind_q == TRC_WRITE);
   assign trc_addr    = addr_q;
   assign trc_summary = (kind_q == TRC_WRITE) ? wsum_q : rd_data[SUM_W-1:0];
   assign trc_master  = ID_W'(MASTER_ID);
   assign trc_region  = ID_W'(REGION_ID);

   // R7
   trc_read_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (trc_valid && !trc_write));
   // R9
   trc_write_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en) |=> (trc_valid && trc_write));
   // R9
   trc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !rd_en) |=> !trc_valid);
   // R4
   trc_addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trc_valid |-> (trc_addr[QW_LSB-1:0] == '0));
endmodule

// File: rtl/qword_ram.sv
module qword_ram #(
   parameter int SIZE_BYTES = 4096,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 128,
   parameter int SUM_W      = 32,
   parameter int ID_W       = 8,
   parameter int MASTER_ID  = 1,
   parameter int REGION_ID  = 1,
   parameter bit TRACE_EN   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   output logic                rd_valid,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [DATA_W/8-1:0] wr_be,
   output logic                trc_valid,
   output logic                trc_write,
   output logic [ADDR_W-1:0]   trc_addr,
   output logic [SUM_W-1:0]    trc_summary,
   output logic [ID_W-1:0]     trc_master,
   output logic [ID_W-1:0]     trc_region
);
   import qram_pkg::*;

   localparam int DEPTH = SIZE_BYTES / QW_BYTES;
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DATA_W != QW_BYTES * 8) begin : g_bad_width
      $error("qword_ram: DATA_W must be one quadword");
   end
   if (SIZE_BYTES % QW_BYTES != 0 || DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_size
      $error("qword_ram: SIZE_BYTES must be a power-of-two count of quadwords");
   end

   logic [IDX_W-1:0]  rd_idx, wr_idx;
   logic [ADDR_W-1:0] rd_aligned, wr_aligned;

   qram_addr_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rd_map (
      .addr(rd_addr), .idx(rd_idx), .aligned(rd_aligned)
   );

   qram_addr_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_wr_map (
      .addr(wr_addr), .idx(wr_idx), .aligned(wr_aligned)
   );

   qram_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_idx   (rd_idx),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .wr_be    (wr_be),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   if (TRACE_EN) begin : g_trace
      qram_tracer #(
         .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUM_W(SUM_W), .ID_W(ID_W),
         .MASTER_ID(MASTER_ID), .REGION_ID(REGION_ID)
      ) u_tracer (
         .clk         (clk),
         .rst_n       (rst_n),
         .rd_en       (rd_en),
         .rd_aligned  (rd_aligned),
         .wr_en       (wr_en),
         .wr_aligned  (wr_aligned),
         .wr_data     (wr_data),
         .rd_data     (rd_data),
         .rd_valid    (rd_valid),
         .trc_valid   (trc_valid),
         .trc_write   (trc_write),
         .trc_addr    (trc_addr),
         .trc_summary (trc_summary),
         .trc_master  (trc_master),
         .trc_region  (trc_region)
      );
   end else begin : g_no_trace
      logic unused_trace;
      assign unused_trace = ^{rd_aligned, wr_aligned};
      assign trc_valid   = 1'b0;
      assign trc_write   = 1'b0;
      assign trc_addr    = '0;
      assign trc_summary = '0;
      assign trc_master  = '0;
      assign trc_region  = '0;
   end
endmodule

// File: tb/qword_ram_test.sv
module qword_ram_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rd_en = 1'b0;
   logic [31:0]  rd_addr = '0;
   logic [127:0] rd_data;
   logic         rd_valid;
   logic         wr_en = 1'b0;
   logic [31:0]  wr_addr = '0;
   logic [127:0] wr_data = '0;
   logic [15:0]  wr_be = '0;
   logic         trc_valid, trc_write;
   logic [31:0]  trc_addr, trc_summary;
   logic [7:0]   trc_master, trc_region;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   qword_ram uut (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
      .trc_valid(trc_valid), .trc_write(trc_write), .trc_addr(trc_addr),
      .trc_summary(trc_summary), .trc_master(trc_master), .trc_region(trc_region)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [127:0] act, input logic [127:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] a, input logic [127:0] d, input logic [15:0] be);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [31:0] a);
      rd_en = 1'b1; rd_addr = a;
      step();
      rd_en = 1'b0;
   endtask

   function automatic logic [127:0] merge(input logic [127:0] old_v,
                                          input logic [127:0] new_v,
                                          input logic [15:0] be);
      logic [127:0] r = old_v;
      for (int i = 0; i < 16; i++) if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
      return r;
   endfunction

   task automatic t_reset();
      chk(rd_valid == 1'b0, "R10 rd_valid after reset", 128'(rd_valid), 128'd0);
      chk(trc_valid == 1'b0, "R10 trc_valid after reset", 128'(trc_valid), 128'd0);
   endtask

   task automatic t_basic();
      logic [127:0] d = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
      wr(32'h040, d, 16'hffff);
      rd(32'h040);
      chk(rd_valid == 1'b1, "R2 rd_valid after rd_en", 128'(rd_valid), 128'd1);
      chk(rd_data == d, "R1 full quadword readback", rd_data, d);
      chk(trc_valid && !trc_write, "R7 read record kind", {trc_valid, trc_write}, 128'b10);
      chk(trc_addr == 32'h040, "R7 read record address", 128'(trc_addr), 128'h40);
      chk(trc_summary == d[31:0], "R7 read record summary", 128'(trc_summary), 128'(d[31:0]));
      chk(trc_master == 8'd1, "R8 master id", 128'(trc_master), 128'd1);
      chk(trc_region == 8'd1, "R8 region id", 128'(trc_region), 128'd1);
      step();
      chk(rd_valid == 1'b0, "R2 rd_valid drops after one cycle", 128'(rd_valid), 128'd0);
      chk(trc_valid == 1'b0, "R9 no record in idle cycle", 128'(trc_valid), 128'd0);
   endtask

   task automatic t_byte_enable();
      logic [127:0] a = 128'h00112233_44556677_8899aabb_ccddeeff;
      logic [127:0] b = 128'hdeadbeef_cafef00d_12345678_9abcdef0;
      logic [127:0] e = merge(a, b, 16'h80f0);
      wr(32'h080, a, 16'hffff);
      wr(32'h080, b, 16'h80f0);
      rd(32'h080);
      chk(rd_data == e, "R3 byte-lane merge", rd_data, e);
      wr(32'h080, ~b, 16'h0000);
      rd(32'h080);
      chk(rd_data == e, "R3 no lanes enabled keeps data", rd_data, e);
   endtask

   task automatic t_align();
      logic [127:0] p = 128'h11111111_22222222_33333333_44444444;
      wr(32'h105, p, 16'hffff);
      rd(32'h10f);
      chk(rd_data == p, "R4 low address bits ignored", rd_data, p);
      chk(trc_addr == 32'h100, "R4 trace address aligned", 128'(trc_addr), 128'h100);
   endtask

   task automatic t_wrap();
      logic [127:0] w = 128'habcdabcd_01234567_89abcdef_fedcba98;
      wr(32'h1030, w, 16'hffff);
      rd(32'h030);
      chk(rd_data == w, "R5 address 0x1030 aliases 0x030", rd_data, w);
      rd(32'h2030);
      chk(rd_data == w, "R5 address 0x2030 aliases 0x030", rd_data, w);
   endtask

   task automatic t_read_first();
      logic [127:0] o = 128'h5555aaaa_5555aaaa_5555aaaa_5555aaaa;
      logic [127:0] n = 128'h0badc0de_0badc0de_0badc0de_0badc0de;
      wr(32'h200, o, 16'hffff);
      rd_en = 1'b1; rd_addr = 32'h200;
      wr_en = 1'b1; wr_addr = 32'h200; wr_data = n; wr_be = 16'hffff;
      step();
      rd_en = 1'b0; wr_en = 1'b0;
      chk(rd_data == o, "R6 same-cycle read returns old data", rd_data, o);
      chk(trc_valid && !trc_write, "R9 read wins the record", {trc_valid, trc_write}, 128'b10);
      chk(trc_summary == o[31:0], "R7 summary of read-first data", 128'(trc_summary), 128'(o[31:0]));
      rd(32'h200);
      chk(rd_data == n, "R6 new data on next read", rd_data, n);
   endtask

   task automatic t_write_trace();
      logic [127:0] d = 128'h01020304_05060708_090a0b0c_cafebabe;
      wr(32'h3a7, d, 16'h000f);
      chk(trc_valid && trc_write, "R9 write record kind", {trc_valid, trc_write}, 128'b11);
      chk(trc_addr == 32'h3a0, "R9 write record address", 128'(trc_addr), 128'h3a0);
      chk(trc_summary == 32'hcafebabe, "R9 write record summary", 128'(trc_summary), 128'hcafebabe);
      chk(trc_master == 8'd1 && trc_region == 8'd1, "R8 ids on write record",
          {trc_master, trc_region}, 128'h0101);
      step();
      chk(trc_valid == 1'b0, "R9 record clears when idle", 128'(trc_valid), 128'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_byte_enable();
      t_align();
      t_wrap();
      t_read_first();
      t_write_trace();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule